// File: doc/BRIEF.md
# Write-Through L1 Data Cache with Per-Request Bypass

This block is a small, non-coherent L1 data cache that serves one compute core. It sits between the core's load/store port and a shared L2. The L2 is seen only as a request/response memory port. Ordinary loads that hit are answered from the L1. Every store is also written through to the L2, so the L1 never holds data that the L2 lacks. The cache keeps no coherence state of any kind.

Some traffic never uses the L1 copy:
- Loads flagged as bypass go to the L2.
- Atomic read-modify-write requests go to the L2. The L2 performs the operation on its copy of the line.

If either kind of request hits a line in the L1, that line is dropped. A later ordinary load then misses and refetches.

Writes made by other cores become visible only when software pulses a one-cycle clear input at a kernel boundary. This input empties the whole cache.

The organisation is direct-mapped, with one 32-bit word per line. Byte address bits [IDX_W+1:2] select the line, and the remaining upper bits form the tag. Only one request is in flight at a time.

Top module: `wt_l1_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready_o` is 1, and neither `resp_valid_o` nor `l2_req_valid_o` is asserted.
- R2: A normal load (`req_op_i`=2'b00, bypass 0) that misses issues one L2 load for its address, returns the L2 data, and fills the line. The same load repeated then hits: it makes no L2 request, and `resp_valid_o` rises in the cycle after acceptance.
- R3: Every store (`req_op_i`=2'b01) issues exactly one L2 write carrying its address and data, hit or miss. While the L2 has not accepted it, the request's op, address and data stay stable. The core response follows L2 acceptance.
- R4: A store that hits updates the L1 copy, so a later load hits with the stored value. A store that misses leaves the line unallocated, so a later load to that address misses.
- R5: A bypass load (`req_op_i`=2'b00, `req_bypass_i`=1) always fetches from L2 and returns L2 data, even on a hit. If it hit, the line is invalidated.
- R6: An atomic add (`req_op_i`=2'b10, operand on `req_wdata_i`) is forwarded to L2 with op 2'b10. The L2's returned old value is passed to the core, and a matching L1 line is invalidated.
- R7: `flush_i` invalidates every line at the clock edge where it is high. `req_ready_o` is 0 in that cycle, so no request is accepted.
- R8: Without a flush, a line read before the L2 copy changed keeps hitting and returns the old value.
- R9: Two addresses with equal index bits and different tags evict each other. Lines at other indices are unaffected.
- R10: While a request is waiting on the L2, `req_ready_o` is 0, and `resp_valid_o` is never high while an L2 request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Core request accepted when high with valid |
| req_op_i | input | 2 | 00 load, 01 store, 10 atomic add |
| req_bypass_i | input | 1 | Load must read L2 |
| req_addr_i | input | ADDR_W | Byte address, word aligned |
| req_wdata_i | input | DATA_W | Store data or atomic operand |
| resp_valid_o | output | 1 | One-cycle response pulse |
| resp_data_o | output | DATA_W | Load or atomic result, 0 for stores |
| l2_req_valid_o | output | 1 | L2 request valid |
| l2_req_ready_i | input | 1 | L2 accepts request |
| l2_req_op_o | output | 2 | L2 op, same encoding as core |
| l2_req_addr_o | output | ADDR_W | L2 address |
| l2_req_wdata_o | output | DATA_W | L2 write data or operand |
| l2_resp_valid_i | input | 1 | L2 read/atomic data valid |
| l2_resp_data_i | input | DATA_W | L2 returned data |

## Verification
The bench changes the L2 copy behind the cache and shows that the L1 keeps returning the old word until a flush. A design that flushed too little, or not at all, would go on returning the stale word after the flush. A bypass load and an atomic are each aimed at a line that is cached. Each is then followed by an ordinary load, which must miss: a design that skipped the invalidate would hit with a dead value. Store hits and store misses are each followed by a load, which exposes a missing L1 update or a write-allocate. An index-conflicting pair of addresses exposes wrong index or tag bit selection.

// File: rtl/l1c_pkg.sv
package l1c_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_AMO   = 2'b10
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_WAIT = 2'b10
  } state_e;
endpackage

// File: rtl/l1c_array.sv
module l1c_array #(
  parameter int LINES  = 64,
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inv_en_i,
  input  logic [IDX_W-1:0]  inv_idx_i
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  valid_q[g] <= 1'b0;
      else if (clr_all_i)                           valid_q[g] <= 1'b0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    valid_q[g] <= 1'b1;
      else if (inv_en_i && inv_idx_i == IDX_W'(g))  valid_q[g] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        tag_q[g]  <= wr_tag_i;
        data_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/l1c_ctrl.sv
module l1c_ctrl
  import l1c_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic              req_bypass_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              l2_req_valid_o,
  input  logic              l2_req_ready_i,
  output logic [1:0]        l2_req_op_o,
  output logic [ADDR_W-1:0] l2_req_addr_o,
  output logic [DATA_W-1:0] l2_req_wdata_o,
  input  logic              l2_resp_valid_i,
  input  logic [DATA_W-1:0] l2_resp_data_i,
  output logic [IDX_W-1:0]  arr_rd_idx_o,
  input  logic              arr_valid_i,
  input  logic [TAG_W-1:0]  arr_tag_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              inv_en_o,
  output logic [IDX_W-1:0]  inv_idx_o
);
  state_e            state_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              fill_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_data_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic              hit, acc, is_ld, local_hit;

  assign req_tag   = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_idx   = req_addr_i[IDX_W+1:2];
  assign arr_rd_idx_o = req_idx;
  assign hit       = arr_valid_i && (arr_tag_i == req_tag);
  assign req_ready_o = (state_q == ST_IDLE) && !flush_i;
  assign acc       = req_valid_i && req_ready_o;
  assign is_ld     = (req_op_i == OP_LOAD);
  assign local_hit = acc && is_ld && !req_bypass_i && hit;

  // bypass loads and atomics drop any stale local copy
  assign inv_en_o  = acc && hit && ((req_op_i == OP_AMO) || (is_ld && req_bypass_i));
  assign inv_idx_o = req_idx;

  always_comb begin
    if (state_q == ST_WAIT) begin
      wr_en_o   = l2_resp_valid_i && fill_q && !flush_i;
      wr_idx_o  = addr_q[IDX_W+1:2];
      wr_tag_o  = addr_q[ADDR_W-1 -: TAG_W];
      wr_data_o = l2_resp_data_i;
    end else begin
      wr_en_o   = acc && (req_op_i == OP_STORE) && hit;
      wr_idx_o  = req_idx;
      wr_tag_o  = req_tag;
      wr_data_o = req_wdata_i;
    end
  end

  assign l2_req_valid_o = (state_q == ST_REQ);
  assign l2_req_op_o    = op_q;
  assign l2_req_addr_o  = addr_q;
  assign l2_req_wdata_o = wdata_q;
  assign resp_valid_o   = resp_valid_q;
  assign resp_data_o    = resp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      op_q         <= '0;
      addr_q       <= '0;
      wdata_q      <= '0;
      fill_q       <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (local_hit) begin
            resp_valid_q <= 1'b1;
            resp_data_q  <= arr_data_i;
          end else if (acc) begin
            op_q    <= req_op_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            fill_q  <= is_ld && !req_bypass_i;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (l2_req_ready_i) begin
            if (op_q == OP_STORE) begin
              resp_valid_q <= 1'b1;
              resp_data_q  <= '0;
              state_q      <= ST_IDLE;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (l2_resp_valid_i) begin
            resp_valid_q <= 1'b1;
            resp_data_q  <= l2_resp_data_i;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      // a flush while a miss is outstanding must not let the fill revive the line
      if (flush_i) fill_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wt_l1_cache.sv
module wt_l1_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic              req_bypass_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              l2_req_valid_o,
  input  logic              l2_req_ready_i,
  output logic [1:0]        l2_req_op_o,
  output logic [ADDR_W-1:0] l2_req_addr_o,
  output logic [DATA_W-1:0] l2_req_wdata_o,
  input  logic              l2_resp_valid_i,
  input  logic [DATA_W-1:0] l2_resp_data_i
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic              arr_valid;
  logic [TAG_W-1:0]  arr_tag;
  logic [DATA_W-1:0] arr_data;
  logic [IDX_W-1:0]  rd_idx, wr_idx, inv_idx;
  logic              wr_en, inv_en;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  l1c_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .flush_i,
    .req_valid_i, .req_ready_o, .req_op_i, .req_bypass_i, .req_addr_i, .req_wdata_i,
    .resp_valid_o, .resp_data_o,
    .l2_req_valid_o, .l2_req_ready_i, .l2_req_op_o, .l2_req_addr_o, .l2_req_wdata_o,
    .l2_resp_valid_i, .l2_resp_data_i,
    .arr_rd_idx_o (rd_idx),
    .arr_valid_i  (arr_valid),
    .arr_tag_i    (arr_tag),
    .arr_data_i   (arr_data),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_tag_o     (wr_tag),
    .wr_data_o    (wr_data),
    .inv_en_o     (inv_en),
    .inv_idx_o    (inv_idx)
  );

  l1c_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .clr_all_i  (flush_i),
    .rd_idx_i   (rd_idx),
    .rd_valid_o (arr_valid),
    .rd_tag_o   (arr_tag),
    .rd_data_o  (arr_data),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_tag_i   (wr_tag),
    .wr_data_i  (wr_data),
    .inv_en_i   (inv_en),
    .inv_idx_i  (inv_idx)
  );
endmodule

// File: rtl/wt_l1_cache_chk.sv
module wt_l1_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_op_i,
  input logic              req_bypass_i,
  input logic              resp_valid_o,
  input logic              l2_req_valid_o,
  input logic              l2_req_ready_i,
  input logic [1:0]        l2_req_op_o,
  input logic [ADDR_W-1:0] l2_req_addr_o,
  input logic [DATA_W-1:0] l2_req_wdata_o
);
  a_r7_flush_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o);

  a_r10_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_valid_o |-> !req_ready_o);

  a_r10_no_resp_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_valid_o |-> !resp_valid_o);

  a_r3_l2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_req_valid_o && !l2_req_ready_i) |=> (l2_req_valid_o && $stable(l2_req_op_o)
      && $stable(l2_req_addr_o) && $stable(l2_req_wdata_o)));

  // R5 and R6: bypass, store and atomic traffic always reaches L2
  a_r5_forward_to_l2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (req_op_i != 2'b00 || req_bypass_i)) |=> l2_req_valid_o);
endmodule

bind wt_l1_cache wt_l1_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_op_i       (req_op_i),
  .req_bypass_i   (req_bypass_i),
  .resp_valid_o   (resp_valid_o),
  .l2_req_valid_o (l2_req_valid_o),
  .l2_req_ready_i (l2_req_ready_i),
  .l2_req_op_o    (l2_req_op_o),
  .l2_req_addr_o  (l2_req_addr_o),
  .l2_req_wdata_o (l2_req_wdata_o)
);

// File: tb/wt_l1_cache_tb_top.sv
`timescale 1ns/1ps
module wt_l1_cache_tb_top;
  localparam int LINES = 64;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        flush_i = 0;
  logic        req_valid_i = 0;
  logic        req_ready_o;
  logic [1:0]  req_op_i = 0;
  logic        req_bypass_i = 0;
  logic [31:0] req_addr_i = 0;
  logic [31:0] req_wdata_i = 0;
  logic        resp_valid_o;
  logic [31:0] resp_data_o;
  logic        l2_req_valid_o;
  logic        l2_req_ready_i = 1;
  logic [1:0]  l2_req_op_o;
  logic [31:0] l2_req_addr_o;
  logic [31:0] l2_req_wdata_o;
  logic        l2_resp_valid_i = 0;
  logic [31:0] l2_resp_data_i = 0;

  always #4 clk_i = ~clk_i;

  wt_l1_cache dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // L2 backing store and behavioural view of what the L1 should hold
  logic [31:0] mem [int unsigned];
  logic [31:0] ref_line [int unsigned];
  int          l2_cnt = 0;
  logic [31:0] last_addr;
  logic [1:0]  last_op;

  function automatic logic [31:0] l2_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : ((a * 32'h9E37) ^ 32'h5A5A0000);
  endfunction

  function automatic int idx_of(input logic [31:0] a);
    return int'((a >> 2) % LINES);
  endfunction

  task automatic ref_fill(input logic [31:0] a, input logic [31:0] d);
    int unsigned gone[$];
    foreach (ref_line[k]) if (idx_of(k) == idx_of(a)) gone.push_back(k);
    foreach (gone[i]) ref_line.delete(gone[i]);
    ref_line[a] = d;
  endtask

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // L2 model: accepts at once, answers loads and atomics one cycle later
  initial begin
    logic [31:0] pend_data;
    bit pend;
    pend = 0;
    forever begin
      @(negedge clk_i);
      l2_resp_valid_i = 0;
      if (pend) begin
        l2_resp_valid_i = 1;
        l2_resp_data_i  = pend_data;
        pend = 0;
      end else if (l2_req_valid_o) begin
        l2_cnt++;
        last_addr = l2_req_addr_o;
        last_op   = l2_req_op_o;
        case (l2_req_op_o)
          2'b01: mem[l2_req_addr_o] = l2_req_wdata_o;
          2'b10: begin
            pend_data = l2_rd(l2_req_addr_o);
            mem[l2_req_addr_o] = pend_data + l2_req_wdata_o;
            pend = 1;
          end
          default: begin
            pend_data = l2_rd(l2_req_addr_o);
            pend = 1;
          end
        endcase
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic byp, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] got, output int lat,
                       output logic rdy_after);
    @(negedge clk_i);
    req_valid_i = 1; req_op_i = op; req_bypass_i = byp; req_addr_i = a; req_wdata_i = wd;
    #1;
    while (!req_ready_o) begin @(negedge clk_i); #1; end
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
    #1;
    rdy_after = req_ready_o;
    lat = 1;
    while (!resp_valid_o) begin @(negedge clk_i); #1; lat++; end
    got = resp_data_o;
  endtask

  task automatic run(input logic [1:0] op, input logic byp, input logic [31:0] a,
                     input logic [31:0] wd, input string rq);
    int n0;
    int lat;
    logic [31:0] exp, got;
    logic rdy;
    bit go_l2;
    n0 = l2_cnt;
    case (op)
      2'b00: if (byp) begin
               exp = l2_rd(a); go_l2 = 1; ref_line.delete(a);
             end else if (ref_line.exists(a)) begin
               exp = ref_line[a]; go_l2 = 0;
             end else begin
               exp = l2_rd(a); go_l2 = 1; ref_fill(a, exp);
             end
      2'b01: begin exp = 0; go_l2 = 1; if (ref_line.exists(a)) ref_line[a] = wd; end
      default: begin exp = l2_rd(a); go_l2 = 1; ref_line.delete(a); end
    endcase
    issue(op, byp, a, wd, got, lat, rdy);
    check(got == exp, {rq, " response data"}, got, exp);
    check((l2_cnt - n0) == int'(go_l2), {rq, " L2 request count"}, l2_cnt - n0, go_l2);
    if (go_l2) begin
      check(last_addr == a && last_op == op, {rq, " L2 address/op"}, last_addr, a);
      check(!rdy, "R10 ready low while L2 pending", rdy, 0);
    end else begin
      check(lat == 1, {rq, " hit latency"}, lat, 1);
    end
    if (op == 2'b01) check(l2_rd(a) == wd, {rq, " L2 written"}, l2_rd(a), wd);
  endtask

  task automatic do_flush();
    int n0;
    bit seen;
    @(negedge clk_i);
    flush_i = 1; req_valid_i = 1; req_op_i = 2'b00; req_bypass_i = 0; req_addr_i = 32'h900;
    #1;
    check(req_ready_o == 0, "R7 no accept during flush", req_ready_o, 0);
    n0 = l2_cnt;
    seen = 0;
    @(negedge clk_i);
    flush_i = 0; req_valid_i = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); #1;
      if (resp_valid_o) seen = 1;
    end
    check(l2_cnt == n0 && !seen, "R7 flush-cycle request ignored", l2_cnt - n0, 0);
    ref_line.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] A = 32'h100, D = 32'h200, E = 32'h104, B = 32'h340, C = 32'h48;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    check(req_ready_o == 1, "R1 ready after reset", req_ready_o, 1);
    check(resp_valid_o == 0 && l2_req_valid_o == 0, "R1 idle outputs", resp_valid_o, 0);

    run(2'b00, 0, A, 0, "R1 first load misses / R2 miss");
    run(2'b00, 0, A, 0, "R2 hit");

    mem[A] = 32'hDEAD0001;
    run(2'b00, 0, A, 0, "R8 stale hit");
    do_flush();
    run(2'b00, 0, A, 0, "R7 fresh after flush");

    run(2'b01, 0, A, 32'h11112222, "R3 store hit");
    mem[A] = 32'h33334444;
    run(2'b00, 0, A, 0, "R4 store hit updated L1");

    run(2'b01, 0, B, 32'h00000055, "R3 store miss");
    run(2'b00, 0, B, 0, "R4 store miss no allocate");

    run(2'b00, 0, C, 0, "R6 prime");
    run(2'b10, 0, C, 32'd5, "R6 atomic");
    run(2'b00, 0, C, 0, "R6 line dropped");

    run(2'b00, 1, A, 0, "R5 bypass on hit");
    run(2'b00, 0, A, 0, "R5 line dropped");

    run(2'b00, 0, E, 0, "R9 other index");
    run(2'b00, 0, D, 0, "R9 conflict evicts");
    run(2'b00, 0, A, 0, "R9 evicted refetch");
    run(2'b00, 0, E, 0, "R9 other index kept");

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule